// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block turns a single host request into the multi-cycle write sequence that a parallel NOR flash needs to erase sectors, program one word, or program a short burst of words through the device's write buffer. It speaks two command-set styles: a direct style, where each operation opens by clearing a status register, and an unlock style, where every command is preceded by a fixed two-write unlock prefix. The host names the style, the operation, the first and last sector, a word offset inside the sector, the data, and a per-sector write-protect mask. It then watches busy, a one-cycle done pulse and a three-bit result code.

On the flash side the block drives a byte address, a write data word and a one-cycle write strobe, plus a one-cycle read strobe used to fetch the current contents before programming. Command bytes are copied onto only those byte lanes that form the command lane of each chip sharing the port. Waiting for the flash to finish is handed to a separate status poller through a start pulse and a done/timeout reply.

Top module: `flash_cmd_seq`

## Requirements
- R1: A command bound to a sector is written at byte address sector_base + offset × PORT_BYTES, where sector_base = sector index << SECT_SHIFT (default 14). A command bound to the target word uses sector_base + word × PORT_BYTES as its base.
- R2: A command byte appears on byte lane i (bits 8i+7..8i) only when (i+1) mod CHIP_BYTES is 0, with zero on every other lane; with 4 port bytes and 2 chip bytes, code 0x20 becomes 0x20002000.
- R3: Direct-style erase (style 0, op 0) of one sector writes 0x50, 0x20, 0xD0 at sector offset 0, then issues one status start.
- R4: Unlock-style erase (style 1, op 0) writes 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, 0x30@0, then issues one status start.
- R5: Direct-style program (op 1) reads the target, then writes 0x50 and 0x40 at the target and then the raw data word at the target, followed by one status start.
- R6: Unlock-style program reads the target, writes 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555 relative to the sector, then the raw data word at the target, followed by one status start.
- R7: If (current contents AND new data) differs from new data, the program ends with result 2 and no write strobe and no status start occur.
- R8: An erase covers sectors first..last in ascending order; sectors whose protect-mask bit is 1 are skipped with no writes, every other sector gets its own erase sequence and status start, and the result is 4 if any sector was skipped (0 otherwise, absent timeouts).
- R9: Direct-style buffered program (op 2) writes 0x50, 0xE8 at the target, waits on one status start, writes (count − 1) as a lane-replicated byte at the target, writes data word j at target + j × PORT_BYTES for j = 0..count−1, writes 0xD0 at the target and issues a second status start.
- R10: Result 3 with no writes is returned for a buffered program in the unlock style, a buffer count of 0 or above BUF_MAX, an erase with first > last, or op code 3.
- R11: Every write strobe lasts exactly one clock, and the address and data on the flash port hold the same value one clock before, during and one clock after it.
- R12: Busy is low after reset and between operations; a request is taken only while busy is low and a request raised while busy has no effect; done is a single-cycle pulse after which busy is low; result codes are 0 ok, 1 timeout, 2 not erased, 3 invalid, 4 protected.
- R13: A status reply with timeout set ends the current sector's sequence; an erase range still proceeds to the next sector, and the final result is 1.
- R14: A program or buffered program aimed at a sector whose protect bit is 1 returns result 4 with no writes and no status start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe, taken while busy is low |
| op_i | input | 2 | 0 erase, 1 program word, 2 buffered program, 3 reserved |
| style_i | input | 1 | 0 direct style, 1 unlock style |
| sec_first_i | input | SW | First (or only) sector index |
| sec_last_i | input | SW | Last sector index of an erase |
| word_i | input | WW | Word offset of the program target inside the sector |
| wdata_i | input | DW | Data word for a single-word program |
| buf_cnt_i | input | CW | Number of words in a buffered program |
| buf_data_i | input | BUF_MAX×DW | Buffered words, word j in bits j×DW upward |
| prot_i | input | NSECT | Per-sector write-protect mask |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 3 | Result code, valid from done |
| fl_addr_o | output | AW | Flash byte address |
| fl_wdata_o | output | DW | Flash write data |
| fl_we_o | output | 1 | Flash write strobe |
| fl_rd_o | output | 1 | Flash read strobe |
| fl_rdata_i | input | DW | Flash read data, valid while the read strobe is high |
| st_start_o | output | 1 | Start pulse to the status poller |
| st_done_i | input | 1 | Status poller finished |
| st_tout_i | input | 1 | Status poller timed out, qualified by st_done_i |

## Verification
The sequencer is driven through each style with erase, single-word program and buffered program, comparing every logged write (address and data) to the sequence written in the requirements, so a wrong command byte, lane, offset base or ordering shows up as a distinct mismatch. Read-back patterns are chosen on both sides of the erased-bits rule, one where the new word only clears bits and one where it needs a cleared bit set, separating a correct veto from a missing or inverted one. Erase ranges with an alternating protect mask and with a timing-out status poller separate per-sector skipping and per-sector continuation from whole-operation aborts, and malformed or protected requests plus a request raised mid-operation show that nothing reaches the flash port when it must not.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  typedef enum logic [1:0] {
    OP_ERASE = 2'd0,
    OP_PROG  = 2'd1,
    OP_BUF   = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    RC_OK        = 3'd0,
    RC_TOUT      = 3'd1,
    RC_NOTERASED = 3'd2,
    RC_INVALID   = 3'd3,
    RC_PROT      = 3'd4
  } rc_e;

  // kind of one micro-step in a command sequence
  typedef enum logic [2:0] {
    K_END, K_CMD, K_CNT, K_DATA, K_BUF, K_READ, K_POLL
  } kind_e;

  typedef struct packed {
    kind_e       kind;
    logic [7:0]  code;  // command byte for K_CMD
    logic [11:0] off;   // word offset from the chosen base
    logic        tgt;   // 1: base is target word, 0: sector base
  } step_t;

  function automatic step_t mk(kind_e k, logic [7:0] c, logic [11:0] o, logic t);
    step_t s;
    s.kind = k;
    s.code = c;
    s.off  = o;
    s.tgt  = t;
    return s;
  endfunction

endpackage

// File: rtl/fcs_lane.sv
// Replicates a command byte onto the command lane of every chip on the port.
module fcs_lane #(
  parameter int PORT_BYTES = 4,
  parameter int CHIP_BYTES = 2
) (
  input  logic [7:0]              code,
  output logic [PORT_BYTES*8-1:0] word
);
  for (genvar i = 0; i < PORT_BYTES; i++) begin : g_lane
    if (((i + 1) % CHIP_BYTES) == 0) begin : g_cmd
      assign word[8*i +: 8] = code;
    end else begin : g_zero
      assign word[8*i +: 8] = 8'h00;
    end
  end
endmodule

// File: rtl/fcs_steps.sv
// Micro-step table for each style and operation.
module fcs_steps
  import fcs_pkg::*;
(
  input  logic       style_b,
  input  op_e        op,
  input  logic [3:0] idx,
  output step_t      step
);
  always_comb begin
    step = mk(K_END, 8'h00, 12'h000, 1'b0);
    unique case (op)
      OP_ERASE: begin
        if (!style_b) begin
          case (idx)
            4'd0: step = mk(K_CMD,  8'h50, 12'h000, 1'b0);
            4'd1: step = mk(K_CMD,  8'h20, 12'h000, 1'b0);
            4'd2: step = mk(K_CMD,  8'hD0, 12'h000, 1'b0);
            4'd3: step = mk(K_POLL, 8'h00, 12'h000, 1'b0);
            default: ;
          endcase
        end else begin
          case (idx)
            4'd0: step = mk(K_CMD,  8'hAA, 12'h555, 1'b0);
            4'd1: step = mk(K_CMD,  8'h55, 12'h2AA, 1'b0);
            4'd2: step = mk(K_CMD,  8'h80, 12'h555, 1'b0);
            4'd3: step = mk(K_CMD,  8'hAA, 12'h555, 1'b0);
            4'd4: step = mk(K_CMD,  8'h55, 12'h2AA, 1'b0);
            4'd5: step = mk(K_CMD,  8'h30, 12'h000, 1'b0);
            4'd6: step = mk(K_POLL, 8'h00, 12'h000, 1'b0);
            default: ;
          endcase
        end
      end
      OP_PROG: begin
        if (!style_b) begin
          case (idx)
            4'd0: step = mk(K_READ, 8'h00, 12'h000, 1'b1);
            4'd1: step = mk(K_CMD,  8'h50, 12'h000, 1'b1);
            4'd2: step = mk(K_CMD,  8'h40, 12'h000, 1'b1);
            4'd3: step = mk(K_DATA, 8'h00, 12'h000, 1'b1);
            4'd4: step = mk(K_POLL, 8'h00, 12'h000, 1'b1);
            default: ;
          endcase
        end else begin
          case (idx)
            4'd0: step = mk(K_READ, 8'h00, 12'h000, 1'b1);
            4'd1: step = mk(K_CMD,  8'hAA, 12'h555, 1'b0);
            4'd2: step = mk(K_CMD,  8'h55, 12'h2AA, 1'b0);
            4'd3: step = mk(K_CMD,  8'hA0, 12'h555, 1'b0);
            4'd4: step = mk(K_DATA, 8'h00, 12'h000, 1'b1);
            4'd5: step = mk(K_POLL, 8'h00, 12'h000, 1'b1);
            default: ;
          endcase
        end
      end
      OP_BUF: begin
        case (idx)
          4'd0: step = mk(K_CMD,  8'h50, 12'h000, 1'b1);
          4'd1: step = mk(K_CMD,  8'hE8, 12'h000, 1'b1);
          4'd2: step = mk(K_POLL, 8'h00, 12'h000, 1'b1);
          4'd3: step = mk(K_CNT,  8'h00, 12'h000, 1'b1);
          4'd4: step = mk(K_BUF,  8'h00, 12'h000, 1'b1);
          4'd5: step = mk(K_CMD,  8'hD0, 12'h000, 1'b1);
          4'd6: step = mk(K_POLL, 8'h00, 12'h000, 1'b1);
          default: ;
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fcs_bus.sv
// One flash bus cycle: write = setup, strobe, hold; read = one strobed cycle.
module fcs_bus #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          ack,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_wdata,
  output logic          fl_we,
  output logic          fl_rd,
  input  logic [DW-1:0] fl_rdata
);
  typedef enum logic [2:0] {B_IDLE, B_SETUP, B_STROBE, B_HOLD, B_READ} ph_e;
  ph_e ph, ph_n;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q, rdata_q;
  logic          load;

  assign load = (ph == B_IDLE) && req;

  always_comb begin
    ph_n = ph;
    unique case (ph)
      B_IDLE:   if (req) ph_n = wr ? B_SETUP : B_READ;
      B_SETUP:  ph_n = B_STROBE;
      B_STROBE: ph_n = B_HOLD;
      B_HOLD:   ph_n = B_IDLE;
      B_READ:   ph_n = B_IDLE;
      default:  ph_n = B_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= B_IDLE;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      ph <= ph_n;
      if (load) begin
        addr_q <= addr;
        data_q <= data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ph == B_READ) rdata_q <= fl_rdata;
  end

  assign ack      = (ph == B_HOLD) || (ph == B_READ);
  assign rdata    = rdata_q;
  assign fl_addr  = addr_q;
  assign fl_wdata = data_q;
  assign fl_we    = (ph == B_STROBE);
  assign fl_rd    = (ph == B_READ);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int PORT_BYTES = 4,
  parameter int CHIP_BYTES = 2,
  parameter int NSECT      = 4,
  parameter int SECT_SHIFT = 14,
  parameter int BUF_MAX    = 4,
  localparam int DW  = PORT_BYTES * 8,
  localparam int PBW = $clog2(PORT_BYTES),
  localparam int SW  = $clog2(NSECT),
  localparam int AW  = SW + SECT_SHIFT,
  localparam int WW  = SECT_SHIFT - PBW,
  localparam int CW  = $clog2(BUF_MAX + 1),
  localparam int JW  = $clog2(BUF_MAX)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_i,
  input  logic [1:0]            op_i,
  input  logic                  style_i,
  input  logic [SW-1:0]         sec_first_i,
  input  logic [SW-1:0]         sec_last_i,
  input  logic [WW-1:0]         word_i,
  input  logic [DW-1:0]         wdata_i,
  input  logic [CW-1:0]         buf_cnt_i,
  input  logic [BUF_MAX*DW-1:0] buf_data_i,
  input  logic [NSECT-1:0]      prot_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [2:0]            result_o,
  output logic [AW-1:0]         fl_addr_o,
  output logic [DW-1:0]         fl_wdata_o,
  output logic                  fl_we_o,
  output logic                  fl_rd_o,
  input  logic [DW-1:0]         fl_rdata_i,
  output logic                  st_start_o,
  input  logic                  st_done_i,
  input  logic                  st_tout_i
);
  typedef enum logic [2:0] {
    S_IDLE, S_NEXT, S_ISSUE, S_BUS, S_CHK, S_POLL, S_SECEND, S_DONE
  } st_e;

  st_e           state, state_n;
  logic [3:0]    k_q, k_n;
  logic [JW-1:0] j_q, j_n;
  logic [SW-1:0] sec_q, sec_n;
  logic          tout_f, tout_n, skip_f, skip_n;
  rc_e           rc_q, rc_n;

  op_e             op_q;
  logic            style_q;
  logic [SW-1:0]   last_q;
  logic [WW-1:0]   word_q;
  logic [DW-1:0]   wdata_q;
  logic [CW-1:0]   cnt_q;
  logic [NSECT-1:0] prot_q;
  logic [DW-1:0]   buf_q [BUF_MAX];

  step_t         step;
  op_e           op_in;
  logic          accept, bad, prot_hit;
  logic          bus_req, bus_ack;
  logic [DW-1:0] bus_rdata, cmd_word, bus_data;
  logic [7:0]    code_c;
  logic [11:0]   off_c;
  logic [AW-1:0] sec_base, tgt_base, addr_c;

  assign op_in    = op_e'(op_i);
  assign accept   = (state == S_IDLE) && req_i;
  assign bad      = (op_in == OP_RSVD)
                 || ((op_in == OP_BUF) && (style_i || (buf_cnt_i == '0) || (buf_cnt_i > CW'(BUF_MAX))))
                 || ((op_in == OP_ERASE) && (sec_first_i > sec_last_i));
  assign prot_hit = (op_in != OP_ERASE) && prot_i[sec_first_i];

  fcs_steps u_steps (.style_b(style_q), .op(op_q), .idx(k_q), .step(step));

  // address and data of the current micro-step
  assign sec_base = {sec_q, {SECT_SHIFT{1'b0}}};
  assign tgt_base = sec_base + (AW'(word_q) << PBW);
  assign off_c    = step.off + ((step.kind == K_BUF) ? 12'(j_q) : 12'd0);
  assign addr_c   = (step.tgt ? tgt_base : sec_base) + (AW'(off_c) << PBW);
  assign code_c   = (step.kind == K_CNT) ? 8'(cnt_q - 1'b1) : step.code;

  fcs_lane #(.PORT_BYTES(PORT_BYTES), .CHIP_BYTES(CHIP_BYTES)) u_lane (
    .code(code_c), .word(cmd_word)
  );

  always_comb begin
    unique case (step.kind)
      K_DATA:  bus_data = wdata_q;
      K_BUF:   bus_data = buf_q[j_q];
      default: bus_data = cmd_word;
    endcase
  end

  fcs_bus #(.AW(AW), .DW(DW)) u_bus (
    .clk(clk), .rst_n(rst_n), .req(bus_req), .wr(step.kind != K_READ),
    .addr(addr_c), .data(bus_data), .ack(bus_ack), .rdata(bus_rdata),
    .fl_addr(fl_addr_o), .fl_wdata(fl_wdata_o), .fl_we(fl_we_o),
    .fl_rd(fl_rd_o), .fl_rdata(fl_rdata_i)
  );

  always_comb begin
    state_n = state;
    k_n     = k_q;
    j_n     = j_q;
    sec_n   = sec_q;
    tout_n  = tout_f;
    skip_n  = skip_f;
    rc_n    = rc_q;
    bus_req = 1'b0;
    unique case (state)
      S_IDLE: if (req_i) begin
        tout_n = 1'b0;
        skip_n = 1'b0;
        k_n    = '0;
        j_n    = '0;
        sec_n  = sec_first_i;
        if (bad) begin
          rc_n = RC_INVALID;  state_n = S_DONE;
        end else if (prot_hit) begin
          rc_n = RC_PROT;     state_n = S_DONE;
        end else begin
          rc_n    = RC_OK;
          state_n = (op_in == OP_ERASE) ? S_NEXT : S_ISSUE;
        end
      end
      S_NEXT: begin
        k_n = '0;
        if (prot_q[sec_q]) begin
          skip_n = 1'b1;  state_n = S_SECEND;
        end else begin
          state_n = S_ISSUE;
        end
      end
      S_ISSUE: begin
        unique case (step.kind)
          K_END:   state_n = S_SECEND;
          K_POLL:  state_n = S_POLL;
          default: begin bus_req = 1'b1; state_n = S_BUS; end
        endcase
      end
      S_BUS: if (bus_ack) begin
        if (step.kind == K_READ) begin
          state_n = S_CHK;
        end else if ((step.kind == K_BUF) && ((CW'(j_q) + 1'b1) != cnt_q)) begin
          j_n = j_q + 1'b1;  state_n = S_ISSUE;
        end else begin
          k_n = k_q + 1'b1;  j_n = '0;  state_n = S_ISSUE;
        end
      end
      S_CHK: begin
        if ((bus_rdata & wdata_q) != wdata_q) begin
          rc_n = RC_NOTERASED;  state_n = S_DONE;
        end else begin
          k_n = k_q + 1'b1;     state_n = S_ISSUE;
        end
      end
      S_POLL: if (st_done_i) begin
        if (st_tout_i) begin
          tout_n = 1'b1;     state_n = S_SECEND;
        end else begin
          k_n = k_q + 1'b1;  state_n = S_ISSUE;
        end
      end
      S_SECEND: begin
        if ((op_q == OP_ERASE) && (sec_q != last_q)) begin
          sec_n = sec_q + 1'b1;  state_n = S_NEXT;
        end else begin
          rc_n    = tout_f ? RC_TOUT : (skip_f ? RC_PROT : RC_OK);
          state_n = S_DONE;
        end
      end
      S_DONE:  state_n = S_IDLE;
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      k_q    <= '0;
      j_q    <= '0;
      sec_q  <= '0;
      tout_f <= 1'b0;
      skip_f <= 1'b0;
      rc_q   <= RC_OK;
    end else begin
      state  <= state_n;
      k_q    <= k_n;
      j_q    <= j_n;
      sec_q  <= sec_n;
      tout_f <= tout_n;
      skip_f <= skip_n;
      rc_q   <= rc_n;
    end
  end

  // request fields, captured once per accepted request
  always_ff @(posedge clk) begin
    if (accept) begin
      op_q    <= op_in;
      style_q <= style_i;
      last_q  <= sec_last_i;
      word_q  <= word_i;
      wdata_q <= wdata_i;
      cnt_q   <= buf_cnt_i;
      prot_q  <= prot_i;
      for (int b = 0; b < BUF_MAX; b++) buf_q[b] <= buf_data_i[b*DW +: DW];
    end
  end

  assign busy_o     = (state != S_IDLE);
  assign done_o     = (state == S_DONE);
  assign result_o   = rc_q;
  assign st_start_o = (state == S_ISSUE) && (step.kind == K_POLL);
endmodule

// File: rtl/fcs_chk.sv
module fcs_chk #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy_o,
  input logic          done_o,
  input logic [2:0]    result_o,
  input logic [AW-1:0] fl_addr_o,
  input logic [DW-1:0] fl_wdata_o,
  input logic          fl_we_o,
  input logic          st_start_o
);
  p_we_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fl_we_o |=> !fl_we_o);
  p_we_setup_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fl_we_o |-> ($stable(fl_addr_o) && $stable(fl_wdata_o)));
  p_we_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fl_we_o |=> ($stable(fl_addr_o) && $stable(fl_wdata_o)));
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!fl_we_o && !st_start_o));
  p_done_ends_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));
  p_result_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (result_o <= 3'd4));
  p_poll_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st_start_o |=> !st_start_o);
endmodule

bind flash_cmd_seq fcs_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o),
  .result_o(result_o), .fl_addr_o(fl_addr_o), .fl_wdata_o(fl_wdata_o),
  .fl_we_o(fl_we_o), .st_start_o(st_start_o)
);

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;
  localparam int CLK_PERIOD = 10;

  logic         clk, rst_n, req;
  logic [1:0]   op;
  logic         style;
  logic [1:0]   first, last;
  logic [11:0]  word;
  logic [31:0]  wdata;
  logic [2:0]   cnt;
  logic [127:0] bufd;
  logic [3:0]   prot;
  logic         busy_o, done_o, fl_we_o, fl_rd_o, st_start_o;
  logic [2:0]   result_o;
  logic [15:0]  fl_addr_o;
  logic [31:0]  fl_wdata_o, rd_val;
  logic         st_done, tout_mode;

  int n_cmp = 0, n_bad = 0;
  logic [15:0] la [32];
  logic [31:0] ld [32];
  int nlog = 0, nst = 0, ndone = 0, stab_err = 0, st_cnt = 0;
  logic [15:0] p_addr;
  logic [31:0] p_data;
  logic        p_we;

  flash_cmd_seq dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .op_i(op), .style_i(style),
    .sec_first_i(first), .sec_last_i(last), .word_i(word), .wdata_i(wdata),
    .buf_cnt_i(cnt), .buf_data_i(bufd), .prot_i(prot),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
    .fl_addr_o(fl_addr_o), .fl_wdata_o(fl_wdata_o), .fl_we_o(fl_we_o),
    .fl_rd_o(fl_rd_o), .fl_rdata_i(rd_val),
    .st_start_o(st_start_o), .st_done_i(st_done), .st_tout_i(tout_mode)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // bus logger, strobe-window monitor and status poller model
  always @(negedge clk) begin
    if (fl_we_o) begin
      if (nlog < 32) begin la[nlog] = fl_addr_o; ld[nlog] = fl_wdata_o; end
      nlog++;
      if (fl_addr_o !== p_addr || fl_wdata_o !== p_data) stab_err++;
    end
    if (p_we && (fl_we_o || fl_addr_o !== p_addr || fl_wdata_o !== p_data)) stab_err++;
    p_addr = fl_addr_o; p_data = fl_wdata_o; p_we = fl_we_o;
    if (done_o) ndone++;
    st_done = 1'b0;
    if (st_cnt > 0) begin st_cnt--; if (st_cnt == 0) st_done = 1'b1; end
    if (st_start_o) begin nst++; st_cnt = 2; end
  end

  function automatic logic [31:0] rep(input logic [7:0] b);
    logic [31:0] w;
    for (int i = 0; i < 4; i++) w[8*i +: 8] = (((i + 1) % 2) == 0) ? b : 8'h00;
    return w;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic expw(input string tag, input int i, input logic [15:0] a, input logic [31:0] d);
    check({tag, " addr"}, {16'h0, la[i]}, {16'h0, a});
    check({tag, " data"}, ld[i], d);
  endtask

  task automatic run_op(input logic [1:0] o, input logic s, input logic [1:0] f,
                        input logic [1:0] l, input logic [11:0] w, input logic [31:0] d,
                        input logic [2:0] c, input logic [3:0] pm, input bit poke);
    int waitc;
    @(negedge clk);
    nlog = 0; nst = 0; ndone = 0;
    op = o; style = s; first = f; last = l; word = w; wdata = d; cnt = c; prot = pm;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      op = 2'd1; first = 2'd2; word = 12'd7; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
    end
    waitc = 0;
    while (!done_o && waitc < 3000) begin @(negedge clk); waitc++; end
    if (waitc >= 3000) check("R12 done never seen", 32'd0, 32'd1);
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R12 reset busy", {31'd0, busy_o}, 32'd0);
    check("R12 reset done", {31'd0, done_o}, 32'd0);
    check("R12 reset strobes", {30'd0, fl_we_o, st_start_o}, 32'd0);
  endtask

  task automatic t_erase_a;
    run_op(2'd0, 1'b0, 2'd1, 2'd1, 12'd0, 32'd0, 3'd0, 4'b0000, 1'b0);
    check("R3 result", {29'd0, result_o}, 32'd0);
    check("R3 write count", nlog, 3);
    check("R3 status starts", nst, 1);
    expw("R3 R2 clear", 0, 16'h4000, 32'h50005000);
    expw("R3 R2 erase", 1, 16'h4000, rep(8'h20));
    expw("R3 confirm", 2, 16'h4000, rep(8'hD0));
  endtask

  task automatic t_erase_b;
    run_op(2'd0, 1'b1, 2'd2, 2'd2, 12'd0, 32'd0, 3'd0, 4'b0000, 1'b0);
    check("R4 result", {29'd0, result_o}, 32'd0);
    check("R4 write count", nlog, 6);
    check("R4 status starts", nst, 1);
    expw("R4 R1 unlock1", 0, 16'h9554, rep(8'hAA));
    expw("R4 R1 unlock2", 1, 16'h8AA8, rep(8'h55));
    expw("R4 setup", 2, 16'h9554, rep(8'h80));
    expw("R4 unlock3", 3, 16'h9554, rep(8'hAA));
    expw("R4 unlock4", 4, 16'h8AA8, rep(8'h55));
    expw("R4 sector cmd", 5, 16'h8000, rep(8'h30));
  endtask

  task automatic t_prog_a;
    rd_val = 32'hFFFF_FFFF;
    run_op(2'd1, 1'b0, 2'd0, 2'd0, 12'd5, 32'h1234_5678, 3'd0, 4'b0000, 1'b0);
    check("R5 result", {29'd0, result_o}, 32'd0);
    check("R5 write count", nlog, 3);
    check("R5 status starts", nst, 1);
    expw("R5 R1 clear", 0, 16'h0014, rep(8'h50));
    expw("R5 program cmd", 1, 16'h0014, rep(8'h40));
    expw("R5 data", 2, 16'h0014, 32'h1234_5678);
  endtask

  task automatic t_prog_b;
    rd_val = 32'hFFFF_0000;
    run_op(2'd1, 1'b1, 2'd3, 2'd3, 12'd2, 32'h0F0F_0000, 3'd0, 4'b0000, 1'b0);
    check("R6 result", {29'd0, result_o}, 32'd0);
    check("R6 write count", nlog, 4);
    expw("R6 unlock1", 0, 16'hD554, rep(8'hAA));
    expw("R6 unlock2", 1, 16'hCAA8, rep(8'h55));
    expw("R6 program cmd", 2, 16'hD554, rep(8'hA0));
    expw("R6 data", 3, 16'hC008, 32'h0F0F_0000);
  endtask

  task automatic t_not_erased;
    rd_val = 32'h0000_FFFF;
    run_op(2'd1, 1'b0, 2'd1, 2'd1, 12'd3, 32'h0001_0001, 3'd0, 4'b0000, 1'b0);
    check("R7 result", {29'd0, result_o}, 32'd2);
    check("R7 no writes", nlog, 0);
    check("R7 no status start", nst, 0);
  endtask

  task automatic t_range;
    run_op(2'd0, 1'b0, 2'd0, 2'd3, 12'd0, 32'd0, 3'd0, 4'b0101, 1'b0);
    check("R8 result", {29'd0, result_o}, 32'd4);
    check("R8 write count", nlog, 6);
    check("R8 status per sector", nst, 2);
    expw("R8 first erased", 0, 16'h4000, rep(8'h50));
    expw("R8 second erased", 3, 16'hC000, rep(8'h50));
    expw("R8 second confirm", 5, 16'hC000, rep(8'hD0));
  endtask

  task automatic t_buf;
    bufd = {32'hDEAD_BEEF, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111};
    run_op(2'd2, 1'b0, 2'd1, 2'd1, 12'd4, 32'd0, 3'd3, 4'b0000, 1'b0);
    check("R9 result", {29'd0, result_o}, 32'd0);
    check("R9 write count", nlog, 7);
    check("R9 status starts", nst, 2);
    expw("R9 clear", 0, 16'h4010, rep(8'h50));
    expw("R9 buffer cmd", 1, 16'h4010, rep(8'hE8));
    expw("R9 count", 2, 16'h4010, rep(8'h02));
    expw("R9 word0", 3, 16'h4010, 32'h1111_1111);
    expw("R9 word1", 4, 16'h4014, 32'h2222_2222);
    expw("R9 word2", 5, 16'h4018, 32'h3333_3333);
    expw("R9 confirm", 6, 16'h4010, rep(8'hD0));
  endtask

  task automatic t_invalid;
    run_op(2'd2, 1'b1, 2'd0, 2'd0, 12'd0, 32'd0, 3'd2, 4'b0000, 1'b0);
    check("R10 buffered unlock style", {29'd0, result_o}, 32'd3);
    check("R10 no writes", nlog, 0);
    run_op(2'd2, 1'b0, 2'd0, 2'd0, 12'd0, 32'd0, 3'd0, 4'b0000, 1'b0);
    check("R10 zero count", {29'd0, result_o}, 32'd3);
    run_op(2'd2, 1'b0, 2'd0, 2'd0, 12'd0, 32'd0, 3'd5, 4'b0000, 1'b0);
    check("R10 count too big", {29'd0, result_o}, 32'd3);
    run_op(2'd0, 1'b0, 2'd3, 2'd1, 12'd0, 32'd0, 3'd0, 4'b0000, 1'b0);
    check("R10 reversed range", {29'd0, result_o}, 32'd3);
    run_op(2'd3, 1'b0, 2'd0, 2'd0, 12'd0, 32'd0, 3'd0, 4'b0000, 1'b0);
    check("R10 reserved op", {29'd0, result_o}, 32'd3);
    check("R10 no writes at all", nlog + nst, 0);
  endtask

  task automatic t_timeout;
    tout_mode = 1'b1;
    run_op(2'd0, 1'b0, 2'd0, 2'd1, 12'd0, 32'd0, 3'd0, 4'b0000, 1'b0);
    tout_mode = 1'b0;
    check("R13 result", {29'd0, result_o}, 32'd1);
    check("R13 both sectors written", nlog, 6);
    check("R13 both sectors polled", nst, 2);
    expw("R13 next sector", 3, 16'h4000, rep(8'h50));
  endtask

  task automatic t_prot_prog;
    rd_val = 32'hFFFF_FFFF;
    run_op(2'd1, 1'b0, 2'd2, 2'd2, 12'd1, 32'h5555_5555, 3'd0, 4'b0100, 1'b0);
    check("R14 prog result", {29'd0, result_o}, 32'd4);
    check("R14 prog no writes", nlog + nst, 0);
    run_op(2'd2, 1'b0, 2'd2, 2'd2, 12'd1, 32'd0, 3'd1, 4'b0100, 1'b0);
    check("R14 buffered result", {29'd0, result_o}, 32'd4);
    check("R14 buffered no writes", nlog + nst, 0);
  endtask

  task automatic t_busy_ignore;
    rd_val = 32'hFFFF_FFFF;
    run_op(2'd0, 1'b0, 2'd0, 2'd0, 12'd0, 32'd0, 3'd0, 4'b0000, 1'b1);
    check("R12 result", {29'd0, result_o}, 32'd0);
    repeat (40) @(negedge clk);
    check("R12 single done", ndone, 1);
    check("R12 only erase writes", nlog, 3);
    expw("R12 last write", 2, 16'h0000, rep(8'hD0));
    check("R12 idle after done", {31'd0, busy_o}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; op = 2'd0; style = 1'b0; first = 2'd0; last = 2'd0;
    word = 12'd0; wdata = 32'd0; cnt = 3'd0; bufd = '0; prot = 4'd0;
    rd_val = 32'hFFFF_FFFF; tout_mode = 1'b0; st_done = 1'b0;
    p_addr = '0; p_data = '0; p_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_erase_a();
    t_erase_b();
    t_prog_a();
    t_prog_b();
    t_not_erased();
    t_range();
    t_buf();
    t_invalid();
    t_timeout();
    t_prot_prog();
    t_busy_ignore();
    check("R11 strobe window", stab_err, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule